// File: doc/BRIEF.md
# Chained-Descriptor Transmit DMA

This block feeds a MAC transmit path from memory. It follows a circular chain of four-word transmit descriptors. Each descriptor has a status word, a control word, a buffer pointer and a pointer to the next descriptor, in that order. Status bit 31 is the ownership flag: a descriptor whose flag is set belongs to the engine. The engine sends the bytes of that descriptor's buffer as a byte stream and then hands the descriptor back by writing its status word with the flag cleared. Control word bit 29 marks the first piece of a frame, bit 30 marks the last piece, and the low `LEN_W` bits hold the byte count.

Software places the chain's base address on `base_addr`, pulses `base_wr` to load the current pointer, holds `dma_en` high and pulses `start`. The engine keeps walking the chain until it finds a descriptor it does not own. It then suspends until the next `start` pulse. `cur_desc` always shows the address of the descriptor the engine is on, or will resume from.

Top module: `tx_desc_dma`

## Requirements
- R1: After reset, `mem_req`, `tx_valid`, `tx_sof` and `tx_eof` are low and `cur_desc` is zero.
- R2: A `base_wr` pulse while the engine is idle loads `base_addr` into `cur_desc`.
- R3: A `start` pulse with `dma_en` high makes the engine read the status word at `cur_desc`. If bit 31 of that word is clear, the engine sends no bytes, writes nothing, leaves `cur_desc` unchanged and waits for the next `start`. A `start` pulse with `dma_en` low has no effect.
- R4: The descriptor words are read at byte offsets 0 (status), 4 (control), 8 (buffer pointer) and 12 (next pointer) from the descriptor address.
- R5: The engine sends exactly the number of bytes held in control bits [LEN_W-1:0]. Bytes go out in ascending address order starting at the buffer pointer, which may be unaligned. The byte at address A is taken from bits [8*(A mod 4)+7 : 8*(A mod 4)] of the 32-bit word at A rounded down to a multiple of 4.
- R6: `tx_sof` is high only on the first byte of a descriptor whose control bit 29 is set. `tx_eof` is high only on the last byte of a descriptor whose control bit 30 is set.
- R7: After the last byte of a descriptor, the engine writes the stored status word with bit 31 cleared, and all other bits unchanged, to the descriptor address.
- R8: After the writeback, `cur_desc` becomes the next pointer, whatever the value of control bit 24. The engine continues at that address, so a chain whose last entry points back to the first wraps around.
- R9: A descriptor with a byte count of zero sends no bytes but is still written back and advanced past.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sof` and `tx_eof` hold their values.
- R11: A memory request holds `mem_req`, `mem_addr` and `mem_we` steady until `mem_ack` is seen.
- R12: If `dma_en` is low when a writeback completes, the engine stops with `cur_desc` at the next pointer. A later `start` with `dma_en` high resumes from that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | AW | Chain base address to load |
| base_wr | input | 1 | Load `base_addr` into the current pointer (idle only) |
| dma_en | input | 1 | Engine enable |
| start | input | 1 | Begin or resume walking the chain |
| cur_desc | output | AW | Address of the current descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| tx_valid | output | 1 | Byte valid |
| tx_data | output | 8 | Byte value |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | MAC accepts the byte |

## Verification
The chain walk is tried with several patterns:
- A lone self-linked descriptor with an unaligned buffer. This separates correct byte-lane selection and counting from word-granular reads.
- A two-entry ring that wraps, split across first-only and last-only flags, with the chain bit clear. This shows that frame marks follow the flags per descriptor and that the next pointer is always followed.
- A zero-length entry, which separates writeback of an empty descriptor from a skip.
- An unowned head entry, which shows suspension without side effects.

Stalling `tx_ready` mid-buffer and dropping `dma_en` mid-walk separate correct holding and stopping from dropped or repeated bytes and runaway fetches.

// File: rtl/tx_desc_dma.sv
module tx_desc_dma #(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          base_wr,
  input  logic          dma_en,
  input  logic          start,
  output logic [AW-1:0] cur_desc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  input  logic          tx_ready
);
  localparam int OWN_B = 31;
  localparam int LAST_B = 30;
  localparam int FIRST_B = 29;
  localparam logic [31:0] OWN_MASK = 32'h1 << OWN_B;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_STAT, S_CTL, S_BUF, S_NEXT, S_WORD, S_SEND, S_WB} st_t;

  st_t              st;
  logic [AW-1:0]    cur, nxt, bptr;
  logic [31:0]      stat_q, word_q;
  logic [LEN_W-1:0] remain;
  logic             first_q, last_q, at_start;

  assign cur_desc  = cur;
  assign mem_req   = (st != S_IDLE) && (st != S_SEND);
  assign mem_we    = (st == S_WB);
  assign mem_wdata = stat_q & ~OWN_MASK;
  assign tx_valid  = (st == S_SEND);
  assign tx_data   = word_q[{bptr[1:0], 3'b000} +: 8];
  assign tx_sof    = tx_valid && first_q && at_start;
  assign tx_eof    = tx_valid && last_q && (remain == ONE);

  always_comb begin
    case (st)
      S_CTL:   mem_addr = cur + AW'(4);
      S_BUF:   mem_addr = cur + AW'(8);
      S_NEXT:  mem_addr = cur + AW'(12);
      S_WORD:  mem_addr = {bptr[AW-1:2], 2'b00};
      default: mem_addr = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur      <= '0;
      nxt      <= '0;
      bptr     <= '0;
      stat_q   <= '0;
      word_q   <= '0;
      remain   <= '0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
      at_start <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (base_wr) cur <= base_addr;
          if (start && dma_en) st <= S_STAT;
        end
        S_STAT: if (mem_ack) begin
          stat_q <= mem_rdata;
          st     <= mem_rdata[OWN_B] ? S_CTL : S_IDLE;
        end
        S_CTL: if (mem_ack) begin
          remain  <= mem_rdata[LEN_W-1:0];
          first_q <= mem_rdata[FIRST_B];
          last_q  <= mem_rdata[LAST_B];
          st      <= S_BUF;
        end
        S_BUF: if (mem_ack) begin
          bptr     <= mem_rdata[AW-1:0];
          at_start <= 1'b1;
          st       <= S_NEXT;
        end
        S_NEXT: if (mem_ack) begin
          nxt <= mem_rdata[AW-1:0];
          st  <= (remain == '0) ? S_WB : S_WORD;
        end
        S_WORD: if (mem_ack) begin
          word_q <= mem_rdata;
          st     <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          bptr     <= bptr + AW'(1);
          remain   <= remain - ONE;
          at_start <= 1'b0;
          if (remain == ONE)          st <= S_WB;
          else if (bptr[1:0] == 2'b11) st <= S_WORD;
        end
        S_WB: if (mem_ack) begin
          cur <= nxt;
          st  <= dma_en ? S_STAT : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R10
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));
  // R7
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[OWN_B]);
  // R6
  mark_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof || tx_eof) |-> tx_valid);
  // R5
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_req));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && !tx_valid && !start |=> !mem_req && !tx_valid);
endmodule

// File: tb/tb_tx_desc_dma.sv
module tb_tx_desc_dma;
  logic        clk = 0, rst_n = 0;
  logic [31:0] base_addr = 0;
  logic        base_wr = 0, dma_en = 0, start = 0, tx_ready = 1;
  logic [31:0] cur_desc, mem_addr, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic        tx_valid, tx_sof, tx_eof;
  logic [7:0]  tx_data;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [0:63];
  logic [7:0]  got_d [0:63];
  bit          got_s [0:63];
  bit          got_e [0:63];
  int nb = 0, nw = 0;

  always #4 clk = ~clk;

  tx_desc_dma dut (.*);

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 0;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1;
      mem_rdata <= mem[mem_addr[7:2]];
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end else mem_ack <= 0;
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && nb < 64) begin
      got_d[nb] = tx_data; got_s[nb] = tx_sof; got_e[nb] = tx_eof; nb++;
    end
    if (rst_n && mem_req && mem_we && mem_ack) nw++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a * 8'd7 + 8'd3;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill();
    for (int w = 0; w < 64; w++)
      mem[w] = {pat(8'(4*w+3)), pat(8'(4*w+2)), pat(8'(4*w+1)), pat(8'(4*w))};
    nb = 0; nw = 0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] st, input logic [31:0] ctl,
                          input logic [31:0] buff, input logic [31:0] nx);
    mem[a/4] = st; mem[a/4+1] = ctl; mem[a/4+2] = buff; mem[a/4+3] = nx;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_base(input logic [31:0] a);
    @(negedge clk); base_addr = a; base_wr = 1;
    @(negedge clk); base_wr = 0;
  endtask

  task automatic kick();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic expect_frame(input int idx, input int a, input int n,
                              input bit f, input bit l, input string req);
    for (int i = 0; i < n; i++) begin
      chk(got_d[idx+i] == pat(8'(a+i)), req, "byte", {24'h0, got_d[idx+i]}, {24'h0, pat(8'(a+i))});
      chk(got_s[idx+i] == (f && i == 0), req, "sof", {31'h0, got_s[idx+i]}, {31'h0, f && i == 0});
      chk(got_e[idx+i] == (l && i == n-1), req, "eof", {31'h0, got_e[idx+i]}, {31'h0, l && i == n-1});
    end
  endtask

  task automatic t_reset();
    chk(!mem_req && !tx_valid && !tx_sof && !tx_eof, "R1", "outputs idle",
        {mem_req, tx_valid, tx_sof, tx_eof}, 0);
    chk(cur_desc == 0, "R1", "cur_desc", cur_desc, 0);
  endtask

  task automatic t_base();
    load_base(32'h24);
    wait_cyc(1);
    chk(cur_desc == 32'h24, "R2", "cur_desc load", cur_desc, 32'h24);
  endtask

  task automatic t_unowned();
    fill();
    put_desc(32'h40, 32'h0000_0011, 32'h6000_0004, 32'h80, 32'h40);
    load_base(32'h40);
    dma_en = 1; kick(); wait_cyc(30);
    chk(nb == 0, "R3", "bytes when unowned", nb, 0);
    chk(nw == 0, "R3", "writes when unowned", nw, 0);
    chk(cur_desc == 32'h40, "R3", "cur_desc kept", cur_desc, 32'h40);
    put_desc(32'h40, 32'h8000_0011, 32'h6000_0004, 32'h80, 32'h40);
    dma_en = 0; kick(); wait_cyc(30);
    chk(nb == 0 && nw == 0, "R3", "start ignored while disabled", nb + nw, 0);
    chk(mem[32'h40/4] == 32'h8000_0011, "R3", "status untouched", mem[16], 32'h8000_0011);
  endtask

  task automatic t_single();
    fill();
    put_desc(32'h40, 32'h8000_0005, 32'h6100_0006, 32'h81, 32'h40);
    load_base(32'h40);
    dma_en = 1; kick(); wait_cyc(60);
    chk(nb == 6, "R5", "byte count", nb, 6);
    expect_frame(0, 32'h81, 6, 1, 1, "R5 R6");
    chk(mem[16] == 32'h0000_0005, "R7", "writeback status", mem[16], 32'h0000_0005);
    chk(nw == 1, "R7", "write count", nw, 1);
    chk(cur_desc == 32'h40, "R4", "self link", cur_desc, 32'h40);
  endtask

  task automatic t_ring();
    fill();
    put_desc(32'h10, 32'h8000_0100, 32'h2000_0003, 32'h80, 32'h30);
    put_desc(32'h30, 32'h8000_0200, 32'h4000_0005, 32'h8C, 32'h10);
    load_base(32'h10);
    dma_en = 1; kick(); wait_cyc(80);
    chk(nb == 8, "R8", "ring byte count", nb, 8);
    expect_frame(0, 32'h80, 3, 1, 0, "R6");
    expect_frame(3, 32'h8C, 5, 0, 1, "R8");
    chk(mem[4] == 32'h0000_0100 && mem[12] == 32'h0000_0200, "R8", "both returned", mem[12], 32'h200);
    chk(cur_desc == 32'h10, "R8", "wrapped to head", cur_desc, 32'h10);
  endtask

  task automatic t_zero();
    fill();
    put_desc(32'h20, 32'h8000_0042, 32'h6000_0000, 32'h80, 32'h00);
    put_desc(32'h00, 32'h0000_0000, 32'h6000_0002, 32'h80, 32'h20);
    load_base(32'h20);
    dma_en = 1; kick(); wait_cyc(40);
    chk(nb == 0, "R9", "no bytes", nb, 0);
    chk(mem[8] == 32'h0000_0042, "R9", "empty writeback", mem[8], 32'h42);
    chk(cur_desc == 32'h00, "R9", "advanced", cur_desc, 0);
  endtask

  task automatic t_stall();
    logic [7:0] d0;
    fill();
    put_desc(32'h40, 32'h8000_0000, 32'h6000_0004, 32'h90, 32'h40);
    load_base(32'h40);
    tx_ready = 0; dma_en = 1; kick();
    while (!tx_valid) @(negedge clk);
    d0 = tx_data;
    wait_cyc(5);
    chk(tx_valid && tx_data == d0 && tx_sof, "R10", "held byte", {24'h0, tx_data}, {24'h0, d0});
    @(negedge clk); tx_ready = 1;
    wait_cyc(2);
    @(negedge clk); tx_ready = 0;
    wait_cyc(4);
    @(negedge clk); tx_ready = 1;
    wait_cyc(30);
    chk(nb == 4, "R10", "no loss or repeat", nb, 4);
    expect_frame(0, 32'h90, 4, 1, 1, "R10");
  endtask

  task automatic t_disable();
    fill();
    put_desc(32'h10, 32'h8000_0000, 32'h2000_0003, 32'h80, 32'h30);
    put_desc(32'h30, 32'h8000_0000, 32'h4000_0005, 32'h8C, 32'h10);
    load_base(32'h10);
    dma_en = 1; kick(); dma_en = 0; wait_cyc(50);
    chk(nb == 3, "R12", "stopped after one", nb, 3);
    chk(cur_desc == 32'h30, "R12", "cur_desc at next", cur_desc, 32'h30);
    chk(mem[12][31], "R12", "second still owned", mem[12], 32'h8000_0000);
    dma_en = 1; kick(); wait_cyc(60);
    chk(nb == 8, "R12", "resumed", nb, 8);
    expect_frame(3, 32'h8C, 5, 0, 1, "R12");
    chk(cur_desc == 32'h10, "R12", "suspended at head", cur_desc, 32'h10);
  endtask

  initial begin
    fill();
    wait_cyc(3);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_base();
    t_unowned();
    t_single();
    t_ring();
    t_zero();
    t_stall();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule